// File: doc/BRIEF.md
# Waveform Step Latch with Bus Stall

This block decodes one waveform address on a processor's external bus. Each 24-bit word written there is one step of a clocking waveform. The low 16 bits hold a 4-bit target-board field and 12 analog-switch states. For an ordinary step, all 16 bits are registered and driven out to the analog boards, and a one-clock latch pulse tells those boards to capture them.

The top byte of the word sets how long that step lasts. A 7-bit count, scaled by a fine or a coarse unit of clock cycles, sets how many cycles the bus wait line is held asserted. The processor cannot complete the write, and so cannot issue the next step, until the wait line drops. This gives each waveform step a hardware-timed length that is finer than a software loop could produce.

A word whose board field is all ones is a readout command, not a switch step. It leaves the latched outputs alone, but its delay still applies.

Top module: `wave_step_latch`

## Requirements
- R1: While reset is held and in the first cycle after it, `switchOut` is 0, `busWait` is 0 and `latchPulse` is 0.
- R2: A write accepted at a clock edge (`wrEn` high and `busWait` low) whose bits 15:12 are not 4'hF drives bits 15:0 of the word onto `switchOut` from that edge onward.
- R3: With bit 23 = 0 (fine unit), `busWait` is high for exactly N cycles right after the accepting edge, where N is the count in bits 22:16 and one fine unit is 1 clock.
- R4: With bit 23 = 1 (coarse unit), `busWait` is high for exactly 8·N cycles right after the accepting edge.
- R5: A count of 0 in bits 22:16 leaves `busWait` low, in either unit.
- R6: A write whose bits 15:12 equal 4'hF (readout command) leaves `switchOut` unchanged and raises no `latchPulse`, while its delay still stalls the bus as in R3/R4.
- R7: A write presented while `busWait` is high is ignored: `switchOut` is unchanged and the remaining stall is neither extended nor restarted.
- R8: The largest count, 127, stalls for 127 cycles in fine units and for 1016 cycles in coarse units.
- R9: `latchPulse` is high for exactly the one cycle after each edge that updates `switchOut`, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one fine delay unit per period |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the waveform address |
| wrData | input | 24 | Written word: unit bit, delay count, board field, switch states |
| busWait | output | 1 | Stall line to the processor bus |
| switchOut | output | 16 | Latched board field (15:12) and switch states (11:0) |
| latchPulse | output | 1 | One-clock capture pulse for the analog boards |

## Verification
The hardest case to reach is a second write that lands while a stall is still running. A real processor never issues one, because it is held by the wait line. The bench forces this case: it drives `wrEn` with a different word in the cycle after a five-cycle stall begins. It then checks that the switch outputs keep the first word and that the stall ends on its original schedule. The readout case needs a known non-zero switch state in place beforehand, so readout words are placed in the vector table right after ordinary steps.

// File: rtl/wave_step_pkg.sv
package wave_step_pkg;

  // Strobes handed from the control to the datapath.
  typedef struct packed {
    logic take;    // write accepted this edge
    logic loadSw;  // switch/board outputs must update
  } stepStrobe_t;

endpackage

// File: rtl/wave_step_ctrl.sv
module wave_step_ctrl
  import wave_step_pkg::*;
#(
  parameter int DATA_W     = 24,
  parameter int SW_W       = 16,
  parameter int CNT_W      = 7,
  parameter int BOARD_W    = 4,
  parameter int FINE_MUL   = 1,
  parameter int COARSE_MUL = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              busWait,
  output stepStrobe_t       strobes
);

  localparam int UNIT_BIT = DATA_W - 1;
  localparam int CNT_HI   = UNIT_BIT - 1;
  localparam int BRD_HI   = SW_W - 1;
  localparam int MAX_MUL  = (COARSE_MUL > FINE_MUL) ? COARSE_MUL : FINE_MUL;
  localparam int DLY_MAX  = ((1 << CNT_W) - 1) * MAX_MUL;
  localparam int DW       = $clog2(DLY_MAX + 1);

  logic [CNT_W-1:0]   stepCount;
  logic [BOARD_W-1:0] boardSel;
  logic               coarse;
  logic               isReadout;
  logic [DW-1:0]      stepCycles;
  logic [DW-1:0]      remaining;
  logic               busy;

  assign stepCount = wrData[CNT_HI -: CNT_W];
  assign boardSel  = wrData[BRD_HI -: BOARD_W];
  assign coarse    = wrData[UNIT_BIT];
  assign isReadout = &boardSel;

  always_comb begin
    if (coarse) stepCycles = DW'(stepCount) * DW'(COARSE_MUL);
    else        stepCycles = DW'(stepCount) * DW'(FINE_MUL);
  end

  assign strobes.take   = wrEn && !busy;
  assign strobes.loadSw = strobes.take && !isReadout;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      remaining <= '0;
    end else if (strobes.take) begin
      busy      <= (stepCycles != '0);
      remaining <= stepCycles;
    end else if (busy) begin
      remaining <= remaining - 1'b1;
      busy      <= (remaining != DW'(1));
    end
  end

  assign busWait = busy;

  AST_ZERO_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.take && stepCount == '0) |=> !busWait);  // R5
  AST_STALL_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.take && stepCount != '0) |=> busWait);  // R3
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busWait |-> (remaining != '0 && remaining <= DW'(DLY_MAX)));  // R8
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (busWait && remaining > DW'(1)) |=> (busWait && remaining == $past(remaining) - 1'b1));  // R7

endmodule

// File: rtl/wave_step_dp.sv
module wave_step_dp
  import wave_step_pkg::*;
#(
  parameter int SW_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  stepStrobe_t     strobes,
  input  logic [SW_W-1:0] swIn,
  output logic [SW_W-1:0] swReg,
  output logic            pulse
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swReg <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= strobes.loadSw;
      if (strobes.loadSw) swReg <= swIn;
    end
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadSw |=> ($stable(swReg) && !pulse));  // R9
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadSw |=> (pulse && swReg == $past(swIn)));  // R2

endmodule

// File: rtl/wave_step_latch.sv
module wave_step_latch
  import wave_step_pkg::*;
#(
  parameter int DATA_W     = 24,
  parameter int SW_W       = 16,
  parameter int CNT_W      = 7,
  parameter int BOARD_W    = 4,
  parameter int FINE_MUL   = 1,
  parameter int COARSE_MUL = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              busWait,
  output logic [SW_W-1:0]   switchOut,
  output logic              latchPulse
);

  stepStrobe_t strobes;

  wave_step_ctrl #(
    .DATA_W(DATA_W), .SW_W(SW_W), .CNT_W(CNT_W), .BOARD_W(BOARD_W),
    .FINE_MUL(FINE_MUL), .COARSE_MUL(COARSE_MUL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .busWait(busWait), .strobes(strobes)
  );

  wave_step_dp #(.SW_W(SW_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .swIn(wrData[SW_W-1:0]), .swReg(switchOut), .pulse(latchPulse)
  );

  AST_READOUT_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !busWait && (&wrData[SW_W-1 -: BOARD_W])) |=> ($stable(switchOut) && !latchPulse));  // R6
  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busWait) |=> $stable(switchOut));  // R7

endmodule

// File: tb/wave_step_latch_bench.sv
module wave_step_latch_bench;

  localparam int CLK_PERIOD = 20;
  localparam int NVEC = 8;

  localparam logic [23:0] VEC_WORD [NVEC] = '{
    24'h0A0FFF, 24'h810000, 24'h000123, 24'h7F5AA5,
    24'hFF3C3C, 24'h83F041, 24'h02E123, 24'h80F000};
  localparam int VEC_WAIT [NVEC] = '{10, 8, 0, 127, 1016, 24, 2, 0};
  localparam logic [15:0] VEC_SW [NVEC] = '{
    16'h0FFF, 16'h0000, 16'h0123, 16'h5AA5,
    16'h3C3C, 16'h3C3C, 16'hE123, 16'hE123};
  localparam logic VEC_LOAD [NVEC] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [23:0] wrData = '0;
  logic        busWait;
  logic [15:0] switchOut;
  logic        latchPulse;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wave_step_latch u_wave_step_latch (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .busWait(busWait), .switchOut(switchOut), .latchPulse(latchPulse)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive one write at a negedge; return at the negedge after the accepting edge.
  task automatic writeWord(input logic [23:0] w);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = w;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic countWait(output int n);
    n = 0;
    while (busWait && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 switchOut in reset", int'(switchOut), 0);
    check("R1 busWait in reset", int'(busWait), 0);
    check("R1 latchPulse in reset", int'(latchPulse), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 switchOut after reset", int'(switchOut), 0);
    check("R1 busWait after reset", int'(busWait), 0);

    // Table walk: R2 R3 R4 R5 R6 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      writeWord(VEC_WORD[i]);
      check(VEC_LOAD[i] ? "R2 switch update" : "R6 readout keeps switches",
            int'(switchOut), int'(VEC_SW[i]));
      check("R9 latch pulse", int'(latchPulse), int'(VEC_LOAD[i]));
      countWait(n);
      check(VEC_WORD[i][23] ? "R4 coarse wait cycles" : "R3 fine wait cycles", n, VEC_WAIT[i]);
      if (n > 0) check("R9 pulse only one cycle", int'(latchPulse), 0);
    end

    // R8: max fine count
    writeWord(24'h7F0001);
    countWait(n);
    check("R8 fine max 127", n, 127);

    // R7: write during stall ignored
    writeWord(24'h050001);
    check("R7 first word latched", int'(switchOut), 16'h0001);
    wrEn = 1'b1;
    wrData = 24'h0AFFFF;
    @(negedge clk);
    wrEn = 1'b0;
    check("R7 stalled write ignored", int'(switchOut), 16'h0001);
    check("R7 no pulse on ignored write", int'(latchPulse), 0);
    countWait(n);
    check("R7 stall not extended", n, 4);
    @(negedge clk);
    check("R7 switches still held", int'(switchOut), 16'h0001);

    // R5: coarse zero count, back-to-back accepted writes
    writeWord(24'h800ABC);
    check("R5 coarse zero no wait", int'(busWait), 0);
    check("R2 zero-count update", int'(switchOut), 16'h0ABC);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule